// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous on-chip requester read and write an external asynchronous static RAM of 8192 bytes. The requester raises a request with a write flag, a 13-bit address and a byte of write data. The controller registers these and plays out a fixed sequence of memory control levels. It then pulses a done flag for one clock. For a read, the byte fetched from the memory is presented at the same time as done.

The memory has no clock, so every minimum time it needs is turned into a whole number of system clocks. Each count comes from a picosecond parameter divided by the clock period and rounded up. The sequence is idle, setup, then either a write pulse or a read wait, then a hold phase, and back to idle. The data bus is split into a driven value, a drive enable and a sampled input; the pad buffer sits outside. Output enable stays high for the whole of every write. The hold phase keeps both strobes high with the bus released, which gives a turnaround gap between any two accesses.

Top module: `asram_port`

## Requirements
- R1: During and after reset, until the first request, the memory is deselected: first enable (active low) at 1 and second enable (active high) at 0. Output enable and write enable are both 1, the data bus is not driven and done is 0.
- R2: A request is taken only in the idle state. A request raised while an access is in progress is ignored and has no effect on the pins or on memory contents. The address and write data taken with a request stay stable on the memory pins for the whole access.
- R3: The two chip enables always have opposite levels. The memory is selected from the first setup cycle through the last hold cycle of an access and is deselected in every idle cycle.
- R4: A write holds write enable high and drives the data for SETUP cycles. It then holds write enable low for PULSE cycles, where PULSE = max(ceil(write-pulse time / clock period), ceil(data-valid time / clock period), 1). The data is driven throughout that low time.
- R5: Output enable is never low while write enable is low or while the controller drives the data bus. It stays high for the whole of a write access.
- R6: A read holds output enable low for WAIT = max(ceil(access time / clock period), 1) cycles. The read data output is loaded from the bus at the clock edge that ends this window. It keeps that value until the next read completes and is not changed by writes.
- R7: SETUP = max(turnaround count, ceil(address-setup time / clock period), 1) cycles. Every access ends with HOLD = max(turnaround count, 1) cycles in which write enable and output enable are high and the bus is released. The controller then returns to idle.
- R8: Done is high for exactly one clock, the first hold cycle of each access, and is low at all other times.
- R9: A read at any address, including 0 and 8191, returns the byte last written there by the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled in idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte address of the access |
| req_wdata_i | input | 8 | Byte to write |
| rsp_rdata_o | output | 8 | Byte returned by the last read |
| rsp_done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 13 | Address pins of the memory |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Value sampled from the data bus |
| mem_ce1_n_o | output | 1 | First chip enable, active low |
| mem_ce2_o | output | 1 | Second chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |

## Verification
A wrong state or a stray count changes the pin levels within one clock. The bench compares every control pin against its expected cycle-by-cycle pattern, so a setup, pulse, wait or hold phase that is one cycle short or long is seen at the first wrong edge. An address or data register loaded outside idle shows up as a pin change in mid-access. A read sampled at the wrong edge returns the marker byte that the memory model puts on an undriven bus, and the check at done catches it. A strobe overlap or bus contention is flagged by the memory model in the cycle it happens.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_RWAIT  = 3'd3,
    ST_HOLD   = 3'd4
  } st_e;

  // clocks needed so that count * period >= time
  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CW      = 2,
  parameter int unsigned N_SETUP = 1,
  parameter int unsigned N_PULSE = 1,
  parameter int unsigned N_WAIT  = 1,
  parameter int unsigned N_HOLD  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr_q,
  input  logic          cnt_zero,
  output st_e           state,
  output logic          accept,
  output logic          finish,
  output logic          load,
  output logic [CW-1:0] load_val
);
  st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    finish   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        accept   = 1'b1;
        st_d     = ST_SETUP;
        load     = 1'b1;
        load_val = CW'(N_SETUP - 1);
      end
      ST_SETUP: if (cnt_zero) begin
        load = 1'b1;
        if (wr_q) begin
          st_d     = ST_WPULSE;
          load_val = CW'(N_PULSE - 1);
        end else begin
          st_d     = ST_RWAIT;
          load_val = CW'(N_WAIT - 1);
        end
      end
      ST_WPULSE, ST_RWAIT: if (cnt_zero) begin
        finish   = 1'b1;
        st_d     = ST_HOLD;
        load     = 1'b1;
        load_val = CW'(N_HOLD - 1);
      end
      ST_HOLD: if (cnt_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/asram_req.sv
module asram_req #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           state,
  input  logic          wr_q,
  input  logic          finish,
  input  logic [DW-1:0] dq_i,
  output logic          ce1_n,
  output logic          ce2,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic          done,
  output logic [DW-1:0] rdata
);
  logic sel;
  logic cap_en;

  assign sel   = (state != ST_IDLE);
  assign ce1_n = ~sel;
  assign ce2   = sel;
  assign we_n  = (state != ST_WPULSE);
  assign oe_n  = (state != ST_RWAIT);
  assign dq_oe = wr_q && ((state == ST_SETUP) || (state == ST_WPULSE));

  assign cap_en = finish && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= dq_i;
  end
endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int unsigned AW       = 13,
  parameter int unsigned DW       = 8,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_AS_PS  = 0,
  parameter int unsigned T_WP_PS  = 8000,
  parameter int unsigned T_DV_PS  = 6000,
  parameter int unsigned T_AA_PS  = 12000,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic [12:0]   req_addr_i,
  input  logic [7:0]    req_wdata_i,
  output logic [7:0]    rsp_rdata_o,
  output logic          rsp_done_o,
  output logic [12:0]   mem_addr_o,
  output logic [7:0]    mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [7:0]    mem_dq_i,
  output logic          mem_ce1_n_o,
  output logic          mem_ce2_o,
  output logic          mem_oe_n_o,
  output logic          mem_we_n_o
);
  localparam int unsigned N_SETUP = max3(TURN_CYC, cyc_ceil(T_AS_PS, CLK_PS), 1);
  localparam int unsigned N_PULSE = max3(cyc_ceil(T_WP_PS, CLK_PS), cyc_ceil(T_DV_PS, CLK_PS), 1);
  localparam int unsigned N_WAIT  = max3(cyc_ceil(T_AA_PS, CLK_PS), 1, 1);
  localparam int unsigned N_HOLD  = max3(TURN_CYC, 1, 1);
  localparam int unsigned N_MAX   = max3(max3(N_SETUP, N_PULSE, 1), N_WAIT, N_HOLD);
  localparam int unsigned CW      = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  st_e           state;
  logic          accept, finish, load, cnt_zero, wr_q;
  logic [CW-1:0] load_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  asram_seq #(
    .CW(CW), .N_SETUP(N_SETUP), .N_PULSE(N_PULSE), .N_WAIT(N_WAIT), .N_HOLD(N_HOLD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req_i), .wr_q(wr_q), .cnt_zero(cnt_zero),
    .state(state), .accept(accept), .finish(finish), .load(load), .load_val(load_val)
  );

  asram_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(cnt_zero)
  );

  asram_req #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr_i(req_wr_i),
    .addr_i(req_addr_i[AW-1:0]), .wdata_i(req_wdata_i[DW-1:0]),
    .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  asram_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_q(wr_q), .finish(finish),
    .dq_i(mem_dq_i[DW-1:0]), .ce1_n(mem_ce1_n_o), .ce2(mem_ce2_o), .oe_n(mem_oe_n_o),
    .we_n(mem_we_n_o), .dq_oe(mem_dq_oe_o), .done(rsp_done_o), .rdata(rsp_rdata_o)
  );

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
endmodule

// File: rtl/asram_port_chk.sv
module asram_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_done_o,
  input logic [7:0]  rsp_rdata_o,
  input logic [12:0] mem_addr_o,
  input logic [7:0]  mem_dq_o,
  input logic        mem_dq_oe_o,
  input logic        mem_ce1_n_o,
  input logic        mem_oe_n_o,
  input logic        mem_we_n_o
);
  // R5: strobes never overlap
  a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n_o && !mem_we_n_o));

  // R5: no drive while the memory may drive
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> mem_oe_n_o);

  // R4: write pulse only with data driven
  a_r4_data_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (mem_dq_oe_o && !mem_ce1_n_o));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done_o |=> !rsp_done_o);

  // R2: address and data steady while selected
  a_r2_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n_o && $past(!mem_ce1_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R7: deselect only after strobes high and bus released
  a_r7_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce1_n_o) |-> $past(mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  // R6: read data changes only together with done
  a_r6_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done_o |-> $stable(rsp_rdata_o));
endmodule

bind asram_port asram_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o),
  .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
  .mem_ce1_n_o(mem_ce1_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o)
);

// File: tb/sim_asram_port.sv
module sim_asram_port;
  localparam int CLK_NS   = 4;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int T_AS     = 0;
  localparam int T_WP     = 8000;
  localparam int T_DV     = 6000;
  localparam int T_AA     = 12000;
  localparam int TURN     = 2;

  function automatic int cdiv(input int t);
    return (t + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SETUP = imax(imax(TURN, cdiv(T_AS)), 1);
  localparam int E_PULSE = imax(imax(cdiv(T_WP), cdiv(T_DV)), 1);
  localparam int E_WAIT  = imax(cdiv(T_AA), 1);
  localparam int E_HOLD  = imax(TURN, 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic [12:0] maddr;
  logic [7:0]  mdq_o, mdq_i;
  logic        mdq_oe, ce1_n, ce2, oe_n, we_n;

  always #(CLK_NS / 2) clk = ~clk;

  asram_port #(
    .CLK_PS(CLK_PS), .T_AS_PS(T_AS), .T_WP_PS(T_WP), .T_DV_PS(T_DV),
    .T_AA_PS(T_AA), .TURN_CYC(TURN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_wr_i(req_wr), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_rdata_o(rdata), .rsp_done_o(done), .mem_addr_o(maddr),
    .mem_dq_o(mdq_o), .mem_dq_oe_o(mdq_oe), .mem_dq_i(mdq_i), .mem_ce1_n_o(ce1_n),
    .mem_ce2_o(ce2), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n)
  );

  // behavioural memory device
  logic [7:0] mem [0:8191];
  assign mdq_i = (!ce1_n && ce2 && !oe_n && we_n) ? mem[maddr] : 8'hEE;

  typedef struct packed {
    logic        sel, oe_n, we_n, dq_oe, done;
    logic [12:0] addr;
    logic [7:0]  dout;
    logic        chk_rd;
    logic [7:0]  rd;
  } exp_t;

  exp_t       q[$];
  logic [7:0] shadow [0:8191];
  logic [7:0] last_rd;
  int  vectors = 0, miscompares = 0;
  bit  idle_seen;
  logic        prev_we_n;
  logic [12:0] prev_addr;
  logic [7:0]  prev_d;
  int  we_low;

  task automatic fail(input string req_tag, input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req_tag, what, act, exp, $time);
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    idle_seen = (q.size() == 0);
    if (idle_seen) e = '{sel:1'b0, oe_n:1'b1, we_n:1'b1, dq_oe:1'b0, done:1'b0,
                         addr:'0, dout:'0, chk_rd:1'b0, rd:'0};
    else e = q.pop_front();
    vectors++;
    // R1 R3: select and enables of opposite polarity
    if (ce1_n !== !e.sel || ce2 !== e.sel) fail("R3", "ce1_n/ce2", {ce1_n, ce2}, {!e.sel, e.sel});
    if (oe_n !== e.oe_n)   fail("R6", "oe_n", oe_n, e.oe_n);
    if (we_n !== e.we_n)   fail("R4", "we_n", we_n, e.we_n);
    if (mdq_oe !== e.dq_oe) fail("R7", "dq_oe", mdq_oe, e.dq_oe);
    if (done !== e.done)   fail("R8", "done", done, e.done);
    if (e.sel && maddr !== e.addr) fail("R2", "addr", maddr, e.addr);
    if (e.dq_oe && mdq_o !== e.dout) fail("R2", "wdata", mdq_o, e.dout);
    if (e.chk_rd && rdata !== e.rd) fail("R9", "rdata", rdata, e.rd);
    // memory model: contention and timing
    if (!oe_n && !we_n)  fail("R5", "oe/we overlap", 0, 1);
    if (mdq_oe && !oe_n) fail("R5", "bus contention", 0, 1);
    if (!we_n) we_low++;
    if (!prev_we_n && we_n) begin
      if (we_low < E_PULSE) fail("R4", "we pulse width", we_low, E_PULSE);
      mem[prev_addr] = prev_d;
      we_low = 0;
    end
    prev_we_n = we_n; prev_addr = maddr; prev_d = mdq_o;
  endtask

  task automatic access(input logic wr, input logic [12:0] a, input logic [7:0] d,
                        input bit junk);
    exp_t e;
    while (!idle_seen) tick();
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d;
    else    last_rd = shadow[a];
    e = '{sel:1'b1, oe_n:1'b1, we_n:1'b1, dq_oe:wr, done:1'b0, addr:a, dout:d,
          chk_rd:1'b0, rd:'0};
    for (int i = 0; i < E_SETUP; i++) q.push_back(e);
    e.dq_oe = wr;
    if (wr) begin e.we_n = 1'b0; for (int i = 0; i < E_PULSE; i++) q.push_back(e); end
    else    begin e.oe_n = 1'b0; for (int i = 0; i < E_WAIT;  i++) q.push_back(e); end
    e.oe_n = 1'b1; e.we_n = 1'b1; e.dq_oe = 1'b0;
    for (int i = 0; i < E_HOLD; i++) begin
      e.done = (i == 0); e.chk_rd = (i == 0); e.rd = last_rd;   // R6 R8 R9
      q.push_back(e);
    end
    tick();
    if (junk) begin  // R2: busy request must be ignored
      req_wr = !wr; req_addr = a ^ 13'h0F0F; req_wdata = ~d;
      tick();
    end
    req = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_NS * 150000);
    fail("WD", "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem[i] = 8'(i) ^ 8'h5A; shadow[i] = 8'(i) ^ 8'h5A;
    end
    last_rd = '0; prev_we_n = 1'b1; prev_addr = '0; prev_d = '0; we_low = 0;
    idle_seen = 1'b1;
    // R1: reset state, then idle with no request
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    // R9: reads of untouched cells, extremes of the address range
    access(1'b0, 13'd5, 8'h00, 1'b0);
    access(1'b1, 13'd0, 8'hA5, 1'b0);
    access(1'b1, 13'd8191, 8'h3C, 1'b0);
    access(1'b0, 13'd0, 8'h00, 1'b0);
    access(1'b0, 13'd8191, 8'h00, 1'b0);
    // R2: busy request ignored; the junk address keeps its old content
    access(1'b1, 13'h1234, 8'h77, 1'b1);
    access(1'b0, 13'h1234, 8'h00, 1'b1);
    access(1'b0, 13'h1234 ^ 13'h0F0F, 8'h00, 1'b0);
    // R5 R7: write/read turnaround and overwrite
    access(1'b1, 13'h0100, 8'h11, 1'b0);
    access(1'b1, 13'h0100, 8'h22, 1'b0);
    access(1'b0, 13'h0100, 8'h00, 1'b0);
    access(1'b1, 13'h0101, 8'hF0, 1'b0);  // R6: rdata kept through a write
    access(1'b0, 13'h0101, 8'h00, 1'b0);
    for (int k = 0; k < 16; k++) access(1'b1, 13'(k * 509), 8'(k * 37 + 1), 1'b0);
    for (int k = 0; k < 16; k++) access(1'b0, 13'(k * 509), 8'h00, 1'b0);
    while (!idle_seen) tick();
    for (int i = 0; i < 4; i++) tick();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule